// File: doc/BRIEF.md
# Parallel CRC-16 Pair Checker

This block validates the integrity of data blocks as they pass through a readout path. Every valid clock it takes one 32-bit word and a block index. A word with bit 31 set opens a block: it restarts two CRC-16 accumulators, one for each of the two serial streams that feed the block. Each later word of that block folds its upper half into the stream-0 accumulator and its lower half into the stream-1 accumulator. The whole word is absorbed in one clock, so the bit-serial lines are never processed one bit at a time.

Every non-opening word is also compared with the values the accumulators held just before it arrived. When the closing CRC-pair word of a block arrives, its two halves therefore meet the CRCs of everything that came before them. A match sets that stream's bit in a 32-bit working status, two bits per block for sixteen blocks. An end-of-event strobe copies the working status to the output register, raises a one-cycle ready pulse and clears the working state for the next event.

Top module: `crc_pair_checker`

## Requirements
- R1: The CRC uses the polynomial x^16+x^12+x^5+1 (0x1021), fed MSB first with no final inversion. The stream-0 accumulator takes word bits [31:16] and the stream-1 accumulator takes bits [15:0]. Both halves are absorbed in the same clock.
- R2: A valid word with bit 31 = 1 is a header. It reloads both accumulators with the CRC of its own halves computed from the seed 0xFFFF, even when a block is already open.
- R3: A valid word with bit 31 = 0 that follows a header in the same event is compared with the accumulator values from before that word. Word bits [30:16] are compared with stream-0 CRC bits [14:0], and word bits [14:0] with stream-1 CRC bits [14:0]. A stream-0 match sets status bit 2·blk, a stream-1 match sets bit 2·blk+1. The word is then absorbed.
- R4: Once set, a status bit stays set until the end of the event, whatever words follow.
- R5: A cycle with the valid strobe low has no effect. A non-header word that arrives before the first header of an event has no effect.
- R6: When the end strobe is high in cycle e, the status output shows the result of the event at the edge that closes cycle e. That result includes any word presented in cycle e. The ready output is high for exactly cycle e+1.
- R7: After reset, the status output and ready are 0. The status output holds its value between end strobes.
- R8: After an end strobe, the working status is cleared and the accumulators are returned to the seed. A header is needed before any compare can happen again.
- R9: Bit 15 of the stream-1 CRC is not compared, so a CRC-pair word that differs only in bit 15 still passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 32 | Incoming block word; bit 31 = 1 marks a header |
| word_vld_i | input | 1 | word_i and blk_i are valid this cycle |
| blk_i | input | 4 | Index of the block the word belongs to |
| evt_end_i | input | 1 | End-of-event strobe |
| status_o | output | 32 | Per-stream pass bits of the last finished event, bit 2·blk+stream |
| status_rdy_o | output | 1 | One-cycle pulse when status_o has been updated |

## Verification
The bench targets these corner cases:
- A CRC-pair word presented in the same cycle as the end strobe. A design that latched the status before adding that word would drop the block's pass bits.
- A compare-matching word sent before any header, and a correct CRC word sent with the valid strobe low. A design that did not gate compares on an open block, or ignored the strobe, would set bits that must stay 0.
- A second header in the middle of a block, a correct result followed by a wrong word, and a flipped bit 15 on stream 1. A design that failed to restart, that cleared bits, or that compared all 16 bits would each report a different status word.
- The lowest and highest block indices, checked for wrong bit placement, and the ready pulse, checked for being held longer than one cycle.

// File: rtl/crcchk_pkg.sv
package crcchk_pkg;
  localparam int unsigned CRC_W      = 16;
  localparam logic [15:0] CRC_POLY   = 16'h1021;
  localparam logic [15:0] CRC_SEED   = 16'hFFFF;
  localparam int unsigned CMP_W      = 15;
  localparam int unsigned STREAMS    = 2;
endpackage

// File: rtl/crcchk_step.sv
// Combinational CRC update over DW data bits, MSB first, as an unrolled chain.
module crcchk_step #(
  parameter int          CW   = 16,
  parameter int          DW   = 16,
  parameter logic [CW-1:0] POLY = 16'h1021
) (
  input  logic [CW-1:0] crc_i,
  input  logic [DW-1:0] dat_i,
  output logic [CW-1:0] crc_o
);
  for (genvar k = 0; k < DW; k++) begin : g_bit
    logic [CW-1:0] cur;
    logic [CW-1:0] nxt;
    logic          fb;
    if (k == 0) begin : g_first
      assign cur = crc_i;
    end else begin : g_next
      assign cur = g_bit[k-1].nxt;
    end
    assign fb  = cur[CW-1] ^ dat_i[DW-1-k];
    assign nxt = {cur[CW-2:0], 1'b0} ^ (fb ? POLY : '0);
  end
  assign crc_o = g_bit[DW-1].nxt;
endmodule

// File: rtl/crcchk_lane.sv
// One stream accumulator with its compare.
module crcchk_lane #(
  parameter int            CW   = 16,
  parameter int            DW   = 16,
  parameter int            MW   = 15,
  parameter logic [CW-1:0] POLY = 16'h1021,
  parameter logic [CW-1:0] SEED = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart_i,
  input  logic          absorb_i,
  input  logic          flush_i,
  input  logic [DW-1:0] dat_i,
  output logic          match_o
);
  logic [CW-1:0] acc;
  logic [CW-1:0] base;
  logic [CW-1:0] nxt;

  assign base = restart_i ? SEED : acc;

  crcchk_step #(.CW(CW), .DW(DW), .POLY(POLY)) i_step (
    .crc_i (base),
    .dat_i (dat_i),
    .crc_o (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || flush_i)              acc <= SEED;
    else if (restart_i || absorb_i)  acc <= nxt;
  end

  assign match_o = absorb_i && (dat_i[MW-1:0] == acc[MW-1:0]);

  assert_acc_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!restart_i && !absorb_i && !flush_i) |=> $stable(acc));

  assert_flush_seed_R8: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (acc == SEED));
endmodule

// File: rtl/crcchk_collect.sv
// Sticky per-stream status collection and event-end capture.
module crcchk_collect #(
  parameter int BLOCKS = 16,
  parameter int NSTR   = 2,
  localparam int IDX_W = $clog2(BLOCKS),
  localparam int STS_W = NSTR * BLOCKS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] blk_i,
  input  logic [NSTR-1:0]  hit_i,
  input  logic             flush_i,
  output logic [STS_W-1:0] status_o,
  output logic             ready_o
);
  logic [STS_W-1:0] set_mask;
  logic [STS_W-1:0] work;

  for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
    for (genvar s = 0; s < NSTR; s++) begin : g_str
      assign set_mask[NSTR*b+s] = hit_i[s] && (blk_i == IDX_W'(b));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush_i) work <= '0;
    else                work <= work | set_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      ready_o  <= 1'b0;
    end else begin
      ready_o <= flush_i;
      if (flush_i) status_o <= work | set_mask;
    end
  end

  assert_rdy_follows_end_R6: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> ready_o);

  assert_rdy_single_R6: assert property (@(posedge clk) disable iff (rst)
    !flush_i |=> !ready_o);

  assert_status_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !flush_i |=> $stable(status_o));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    !flush_i |=> ((work & $past(work)) == $past(work)));

  assert_work_clear_R8: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (work == '0));
endmodule

// File: rtl/crc_pair_checker.sv
module crc_pair_checker #(
  parameter int BLOCKS  = 16,
  parameter int WORD_W  = 32,
  localparam int IDX_W  = $clog2(BLOCKS),
  localparam int HALF_W = WORD_W / 2,
  localparam int STS_W  = crcchk_pkg::STREAMS * BLOCKS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic [IDX_W-1:0]  blk_i,
  input  logic              evt_end_i,
  output logic [STS_W-1:0]  status_o,
  output logic              status_rdy_o
);
  import crcchk_pkg::*;

  localparam int NSTR = STREAMS;

  logic            armed;
  logic            hdr_w;
  logic            body_w;
  logic [NSTR-1:0] hit;

  assign hdr_w  = word_vld_i && word_i[WORD_W-1];
  assign body_w = word_vld_i && !word_i[WORD_W-1] && armed;

  always_ff @(posedge clk) begin
    if (rst || evt_end_i) armed <= 1'b0;
    else if (hdr_w)       armed <= 1'b1;
  end

  // stream 0 takes the upper half, stream 1 the lower half
  for (genvar s = 0; s < NSTR; s++) begin : g_lane
    crcchk_lane #(
      .CW(CRC_W), .DW(HALF_W), .MW(CMP_W), .POLY(CRC_POLY), .SEED(CRC_SEED)
    ) i_lane (
      .clk       (clk),
      .rst       (rst),
      .restart_i (hdr_w),
      .absorb_i  (body_w),
      .flush_i   (evt_end_i),
      .dat_i     (word_i[WORD_W-1-s*HALF_W -: HALF_W]),
      .match_o   (hit[s])
    );
  end

  crcchk_collect #(.BLOCKS(BLOCKS), .NSTR(NSTR)) i_collect (
    .clk      (clk),
    .rst      (rst),
    .blk_i    (blk_i),
    .hit_i    (hit),
    .flush_i  (evt_end_i),
    .status_o (status_o),
    .ready_o  (status_rdy_o)
  );

  assert_hit_gate_R5: assert property (@(posedge clk) disable iff (rst)
    !body_w |-> (hit == '0));

  assert_rdy_then_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (status_rdy_o && !evt_end_i) |=> !status_rdy_o);
endmodule

// File: tb/test_crc_pair_checker.sv
module test_crc_pair_checker;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] word_i;
  logic        word_vld_i;
  logic [3:0]  blk_i;
  logic        evt_end_i;
  logic [31:0] status_o;
  logic        status_rdy_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  crc_pair_checker i_crc_pair_checker (
    .clk(clk), .rst(rst), .word_i(word_i), .word_vld_i(word_vld_i),
    .blk_i(blk_i), .evt_end_i(evt_end_i),
    .status_o(status_o), .status_rdy_o(status_rdy_o)
  );

  // reference model state
  logic [15:0] m_a0, m_a1;
  logic        m_arm;
  logic [31:0] m_work, m_stat;

  // R1: bit-serial reference, MSB first
  function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r = c;
    for (int i = 15; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_a0 = 16'hFFFF; m_a1 = 16'hFFFF; m_arm = 1'b0; m_work = '0; m_stat = '0;
  endtask

  task automatic send(input logic [31:0] w, input int b, input bit v, input bit e);
    @(negedge clk);
    word_i = w; blk_i = 4'(b); word_vld_i = v; evt_end_i = e;
    if (v) begin
      if (w[31]) begin
        m_a0 = crc_ref(16'hFFFF, w[31:16]);
        m_a1 = crc_ref(16'hFFFF, w[15:0]);
        m_arm = 1'b1;
      end else if (m_arm) begin
        if (w[30:16] == m_a0[14:0]) m_work[2*b]   = 1'b1;
        if (w[14:0]  == m_a1[14:0]) m_work[2*b+1] = 1'b1;
        m_a0 = crc_ref(m_a0, w[31:16]);
        m_a1 = crc_ref(m_a1, w[15:0]);
      end
    end
    if (e) begin
      m_stat = m_work; m_work = '0; m_arm = 1'b0;
      m_a0 = 16'hFFFF; m_a1 = 16'hFFFF;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    word_vld_i = 1'b0; evt_end_i = 1'b0; word_i = '0;
  endtask

  function automatic logic [31:0] sample(input int b, input int i);
    return ((32'(b) * 32'h9E37_79B1) ^ (32'(i + 1) * 32'h0019_660D)) & 32'h7FFF_FFFF;
  endfunction

  // send header and samples of one block
  task automatic body(input int b, input int n);
    send(32'h8000_0000 | (32'(b) << 8) | 32'(n), b, 1'b1, 1'b0);
    for (int i = 0; i < n; i++) send(sample(b, i), b, 1'b1, 1'b0);
  endtask

  function automatic logic [31:0] pair_word(input int mode);
    logic [15:0] h = m_a0, l = m_a1;
    if (mode == 1 || mode == 3) h = h ^ 16'h0001;
    if (mode == 2 || mode == 3) l = l ^ 16'h0008;
    if (mode == 4)              l = l ^ 16'h8000;
    return {1'b0, h[14:0], l};
  endfunction

  // table: block index, sample count, corruption mode
  // mode 0 clean, 1 bad stream 0, 2 bad stream 1, 3 both bad, 4 bit 15 of stream 1 flipped
  localparam int NTV = 8;
  localparam int TV_BLK [NTV] = '{0, 15, 5, 9, 3, 12, 7, 1};
  localparam int TV_N   [NTV] = '{7, 1, 3, 0, 5, 2, 7, 4};
  localparam int TV_MOD [NTV] = '{0, 0, 1, 2, 3, 4, 0, 2};

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    rst = 1'b1; word_i = '0; word_vld_i = 1'b0; blk_i = '0; evt_end_i = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R7 reset status", status_o, 32'h0);
    check("R7 reset ready", 32'(status_rdy_o), 32'h0);
    rst = 1'b0;

    // event 1: table walk
    for (int t = 0; t < NTV; t++) begin
      body(TV_BLK[t], TV_N[t]);
      send(pair_word(TV_MOD[t]), TV_BLK[t], 1'b1, 1'b0);
    end
    send(32'h0, 0, 1'b0, 1'b1);
    idle();
    check("R3 R1 event status", status_o, m_stat);
    check("R6 ready pulse", 32'(status_rdy_o), 32'h1);
    for (int t = 0; t < NTV; t++) begin
      if (TV_MOD[t] == 0 || TV_MOD[t] == 4)
        check("R3 R9 clean block bits", 32'(status_o[2*TV_BLK[t] +: 2]), 32'h3);
    end
    idle();
    check("R6 ready single cycle", 32'(status_rdy_o), 32'h0);
    check("R7 status hold", status_o, m_stat);

    // event 2: pre-header word, valid-low word, restart, sticky, end with word
    send({1'b0, 15'h7FFF, 16'hFFFF}, 2, 1'b1, 1'b0);     // R5 before header
    body(6, 3);
    send(pair_word(0), 6, 1'b0, 1'b0);                   // R5 valid low
    body(4, 5);
    body(4, 2);                                          // R2 restart mid-block
    send(pair_word(0), 4, 1'b1, 1'b0);
    body(1, 2);
    send(pair_word(0), 1, 1'b1, 1'b0);
    send(32'h1234_5678, 1, 1'b1, 1'b0);                  // R4 wrong word after pass
    body(7, 3);
    send(pair_word(0), 7, 1'b1, 1'b1);                   // R6 word with end
    idle();
    check("R5 R6 R2 R4 event status", status_o, m_stat);
    check("R5 pre-header ignored", 32'(status_o[5:4]), 32'h0);
    check("R5 valid-low ignored", 32'(status_o[13:12]), 32'h0);
    check("R2 restart block passes", 32'(status_o[9:8]), 32'h3);
    check("R4 sticky after wrong word", 32'(status_o[3:2]), 32'h3);
    check("R6 same-cycle word counted", 32'(status_o[15:14]), 32'h3);

    // event 3: body words only, no header
    send({1'b0, 15'h7FFF, 16'hFFFF}, 0, 1'b1, 1'b0);
    send(32'h0000_0000, 0, 1'b1, 1'b1);
    idle();
    check("R8 cleared, header needed", status_o, 32'h0);
    check("R8 model agrees", status_o, m_stat);

    idle();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule